// File: doc/BRIEF.md
# Compare-Based GPIO Bank Interrupt Unit

This block raises interrupts for one bank of eight general-purpose input pins. Its basic detector works on levels. A pin counts as active when its synchronized input level differs from that pin's compare bit and the pin's mask bit is set. Edge detection is added in hardware on top of this level detector. When an edge-mode pin goes active, its compare bit is reloaded with the level just sampled, which re-arms it for the opposite transition. An event is reported only when the new level matches the configured direction, or on every transition in both-edge mode.

Software controls the unit through a simple one-cycle write port. The port selects one of six targets: set or clear mask bits, set or clear compare bits, load the whole edge configuration word, and clear pending bits. Each pin owns a 4-bit mode field in the configuration word. The outputs are a per-pin pending vector, the current compare bits, and one combined bank interrupt line.

Top module: `gpio_cmp_irq`

## Requirements
- R1: After reset, every pending bit, every compare bit, every mask bit and every mode field is 0, and `irq_o` is low.
- R2: A write with `wr_en` high acts on the target given by `wr_sel`:
    - 0 sets mask bits.
    - 1 clears mask bits.
    - 2 sets compare bits.
    - 3 clears compare bits.
    - 4 loads the configuration word.
    - 5 clears pending bits.
  For targets 0 to 3 and 5, only bit positions written with 1 change. Compare changes are visible on `cmp_o` on the next cycle.
- R3: Each pin input passes through two flops before comparison. The active condition is (synchronized level XOR compare) AND mask. In level mode, the pending bit is a registered copy of the active condition, so a pin change reaches `pend_o` on the third rising edge after it is applied.
- R4: A pin whose mask bit is 0 never becomes active and never sets its pending bit.
- R5: Rising mode (field low bits 2): on an active cycle, compare is loaded with the sampled level, and the pending bit is set only if that level is 1.
- R6: Falling mode (field low bits 1): on an active cycle, compare is loaded with the sampled level, and the pending bit is set only if that level is 0.
- R7: Both-edge mode (field low bits 3): on every active cycle, compare is loaded with the sampled level and the pending bit is set.
- R8: In the edge modes, pending bits are sticky until cleared through target 5. If a clear and a new event for the same pin arrive in the same cycle, the pin stays pending.
- R9: Pin n's field occupies configuration bits [4n+3:4n]. Only its two low bits select the mode (0 means level mode); the two upper bits have no effect. A write to target 4 clears all pending bits on the following cycle.
- R10: A software write to a compare bit (target 2 or 3) wins over an automatic reload of that bit in the same cycle. Bits not written still take their automatic reload.
- R11: `irq_o` is high exactly when at least one bit of `pend_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 8 | Raw asynchronous pin levels |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 3 | Write target code (see R2) |
| wr_data | input | 32 | Write data; bit n addresses pin n, or the full word for target 4 |
| pend_o | output | 8 | Per-pin pending flags |
| cmp_o | output | 8 | Current compare bits |
| irq_o | output | 1 | Bank interrupt, OR of pending flags |

## Verification
The bench goes after these corner cases, each at the cycle where it matters:
- **Reload direction in the edge modes.** A unit that reported the re-arming half of a rising or falling edge would show a pending bit one transition too early.
- **Collision between a compare write and an automatic reload.** A unit that let the reload win would leave `cmp_o` at the sampled level instead of the written value.
- **Clear of a pending bit in the same cycle as a new event.** A unit that let the clear win would lose that event.
- **Configuration write in the same cycle as an event.** A unit with the wrong ordering would leave a pending bit set after the write.
- **Configuration fields with the upper two bits set.** A unit that decoded the full field would treat these pins as level pins and follow the live level.

The stimulus mixes modes across pins, changes the mask mid-run, and holds pin levels for irregular stretches, so that both short and long pulses cross the synchronizer.

// File: rtl/gpio_cmp_pkg.sv
package gpio_cmp_pkg;

    typedef enum logic [2:0] {
        SEL_MASK_SET = 3'd0,
        SEL_MASK_CLR = 3'd1,
        SEL_CMP_SET  = 3'd2,
        SEL_CMP_CLR  = 3'd3,
        SEL_MODE_WR  = 3'd4,
        SEL_PEND_CLR = 3'd5
    } wr_target_e;

    typedef enum logic [1:0] {
        MODE_LEVEL   = 2'd0,
        MODE_FALLING = 2'd1,
        MODE_RISING  = 2'd2,
        MODE_BOTH    = 2'd3
    } pin_mode_e;

endpackage

// File: rtl/gpio_cmp_sync.sv
module gpio_cmp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= chain_d[i];
            end
        end
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_cmp_pin.sv
module gpio_cmp_pin
    import gpio_cmp_pkg::*;
(
    input  logic       level,
    input  logic       cmp_bit,
    input  logic       mask_bit,
    input  logic [1:0] mode,
    output logic       active,
    output logic       edge_mode,
    output logic       report,
    output logic       reload
);
    pin_mode_e mode_e;

    always_comb begin
        mode_e    = pin_mode_e'(mode);
        active    = (level ^ cmp_bit) & mask_bit;
        edge_mode = (mode_e != MODE_LEVEL);
        reload    = active & edge_mode;
        unique case (mode_e)
            MODE_RISING:  report = active & level;
            MODE_FALLING: report = active & ~level;
            MODE_BOTH:    report = active;
            default:      report = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_cmp_irq.sv
module gpio_cmp_irq
    import gpio_cmp_pkg::*;
#(
    parameter int PINS    = 8,
    parameter int FIELD_W = 4,
    parameter int SYNC_N  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  pin_in,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [7:0]  pend_o,
    output logic [7:0]  cmp_o,
    output logic        irq_o
);
    localparam int CFG_W = PINS * FIELD_W;

    typedef struct packed {
        logic [PINS-1:0]  mask;
        logic [PINS-1:0]  cmp;
        logic [PINS-1:0]  pend;
        logic [CFG_W-1:0] cfg;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic [PINS-1:0] level;
    logic [PINS-1:0] active;
    logic [PINS-1:0] edge_mode;
    logic [PINS-1:0] report;
    logic [PINS-1:0] reload;
    logic [PINS-1:0] wr_bits;
    logic [PINS-1:0] mask_q;
    wr_target_e      target;

    gpio_cmp_sync #(.WIDTH(PINS), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (level)
    );

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        gpio_cmp_pin u_pin (
            .level     (level[n]),
            .cmp_bit   (st_q.cmp[n]),
            .mask_bit  (st_q.mask[n]),
            .mode      (st_q.cfg[n*FIELD_W +: 2]),
            .active    (active[n]),
            .edge_mode (edge_mode[n]),
            .report    (report[n]),
            .reload    (reload[n])
        );
    end

    always_comb begin
        target  = wr_target_e'(wr_sel);
        wr_bits = wr_data[PINS-1:0];
        st_d    = st_q;

        for (int n = 0; n < PINS; n++) begin
            if (edge_mode[n]) begin
                if (reload[n]) begin
                    st_d.cmp[n] = level[n];
                end
                st_d.pend[n] = (st_q.pend[n]
                               & ~(wr_en && target == SEL_PEND_CLR && wr_bits[n]))
                               | report[n];
            end else begin
                st_d.pend[n] = active[n];
            end
        end

        if (wr_en) begin
            unique case (target)
                SEL_MASK_SET: st_d.mask = st_q.mask | wr_bits;
                SEL_MASK_CLR: st_d.mask = st_q.mask & ~wr_bits;
                SEL_CMP_SET:  st_d.cmp  = st_d.cmp | wr_bits;
                SEL_CMP_CLR:  st_d.cmp  = st_d.cmp & ~wr_bits;
                SEL_MODE_WR: begin
                    st_d.cfg  = wr_data[CFG_W-1:0];
                    st_d.pend = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;
    assign pend_o = st_q.pend;
    assign cmp_o  = st_q.cmp;
    assign irq_o  = |st_q.pend;
endmodule

// File: rtl/gpio_cmp_irq_chk.sv
module gpio_cmp_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic [7:0]  pend_o,
    input logic [7:0]  cmp_o,
    input logic [7:0]  mask_q,
    input logic        irq_o
);
    p_cmp_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd2) |=> ((cmp_o & $past(wr_data[7:0])) == $past(wr_data[7:0])));

    p_cmp_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd3) |=> ((cmp_o & $past(wr_data[7:0])) == 8'h00));

    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd0) |=> ((mask_q & $past(wr_data[7:0])) == $past(wr_data[7:0])));

    p_mode_wr_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd4) |=> (pend_o == 8'h00));

    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 8'h00 && pend_o == 8'h00) |=> (pend_o == 8'h00));

    p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (pend_o != 8'h00));
endmodule

bind gpio_cmp_irq gpio_cmp_irq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .pend_o  (pend_o),
    .cmp_o   (cmp_o),
    .mask_q  (mask_q),
    .irq_o   (irq_o)
);

// File: tb/gpio_cmp_irq_bench.sv
module gpio_cmp_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  pend_o;
    logic [7:0]  cmp_o;
    logic        irq_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    bit    done    = 1'b0;

    // reference model state, one entry per pin
    int m_s1 [8];
    int m_s2 [8];
    int m_cmp [8];
    int m_mask [8];
    int m_mode [8];
    int m_pend [8];
    int lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    gpio_cmp_irq u_gpio_cmp_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pend_o  (pend_o),
        .cmp_o   (cmp_o),
        .irq_o   (irq_o)
    );

    function automatic int exp_vec(input int which);
        int v = 0;
        for (int n = 0; n < 8; n++) begin
            if (which == 0 && m_pend[n] != 0) v |= (1 << n);
            if (which == 1 && m_cmp[n] != 0)  v |= (1 << n);
        end
        return v;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural model advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < 8; n++) begin
                m_s1[n] = 0; m_s2[n] = 0; m_cmp[n] = 0;
                m_mask[n] = 0; m_mode[n] = 0; m_pend[n] = 0;
            end
        end else begin
            for (int n = 0; n < 8; n++) begin
                int act, md, rep, ncmp, npend, bitw;
                act  = ((m_s2[n] != m_cmp[n]) && m_mask[n] != 0) ? 1 : 0;
                md   = m_mode[n] & 3;
                ncmp = m_cmp[n];
                bitw = wr_data[n];
                if (md == 0) begin
                    npend = act;
                end else begin
                    rep = 0;
                    if (act != 0) begin
                        ncmp = m_s2[n];
                        if (md == 3) rep = 1;
                        else if (md == 2 && m_s2[n] == 1) rep = 1;
                        else if (md == 1 && m_s2[n] == 0) rep = 1;
                    end
                    npend = m_pend[n];
                    if (wr_en && wr_sel == 3'd5 && bitw != 0) npend = 0;
                    if (rep != 0) npend = 1;
                end
                if (wr_en && wr_sel == 3'd2 && bitw != 0) ncmp = 1;
                if (wr_en && wr_sel == 3'd3 && bitw != 0) ncmp = 0;
                if (wr_en && wr_sel == 3'd0 && bitw != 0) m_mask[n] = 1;
                if (wr_en && wr_sel == 3'd1 && bitw != 0) m_mask[n] = 0;
                if (wr_en && wr_sel == 3'd4) begin
                    m_mode[n] = (wr_data >> (4 * n)) & 15;
                    npend = 0;
                end
                m_cmp[n]  = ncmp;
                m_pend[n] = npend;
                m_s2[n]   = m_s1[n];
                m_s1[n]   = pin_in[n];
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "pend_o", pend_o, exp_vec(0));
            check(cur_req, "cmp_o", cmp_o, exp_vec(1));
            check("R11", "irq_o", irq_o, (exp_vec(0) != 0) ? 1 : 0);
        end
    end

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel[2:0]; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) @(negedge clk);
    endtask

    task automatic wander(input int cycles, input int cmp_pokes, input int clr_pokes);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            lfsr = (lfsr << 1) ^ (((lfsr >> 31) ^ (lfsr >> 21) ^ (lfsr >> 1) ^ lfsr) & 1);
            if ((lfsr & 3) == 0) pin_in = pin_in ^ lfsr[11:4];
            wr_en = 1'b0;
            if (cmp_pokes != 0 && (lfsr[15:13] == 3'd0)) begin
                wr_en = 1'b1; wr_sel = lfsr[16] ? 3'd2 : 3'd3; wr_data = {24'd0, lfsr[27:20]};
            end else if (clr_pokes != 0 && (lfsr[15:13] == 3'd1)) begin
                wr_en = 1'b1; wr_sel = 3'd5; wr_data = {24'd0, lfsr[27:20]};
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "pend at reset", pend_o, 0);
        check("R1", "cmp at reset", cmp_o, 0);
        check("R1", "irq at reset", irq_o, 0);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R2";
        wr(0, 32'hA5); wr(2, 32'h0F); wr(3, 32'h03);
        check("R2", "cmp after set/clear", cmp_o, 8'h0C);
        wr(1, 32'hFF); wr(3, 32'hFF);

        cur_req = "R3";
        wr(0, 32'hFF); wr(2, 32'h0F);
        pin_in = 8'h00; idle(4);
        check("R3", "level active low half", pend_o, 8'h0F);
        pin_in = 8'hF0; idle(1); idle(1);
        check("R3", "two cycles after change", pend_o, 8'h0F);
        idle(1);
        check("R3", "third edge after change", pend_o, 8'hFF);
        wander(60, 0, 0);

        cur_req = "R4";
        wr(1, 32'hCC);
        wander(60, 0, 0);
        wr(1, 32'hFF);
        wander(20, 0, 0);

        cur_req = "R5";
        pin_in = 8'h00; wr(4, 32'h2222_2222); wr(2, 32'hFF); wr(0, 32'hFF);
        idle(5);
        check("R5", "low level not reported", pend_o, 0);
        check("R5", "compare re-armed", cmp_o, 0);
        pin_in = 8'h01; idle(4);
        check("R5", "rising reported", pend_o, 8'h01);
        wander(80, 0, 1);

        cur_req = "R6";
        wr(4, 32'h9999_9999); // upper field bits set; still falling (R9)
        wander(80, 0, 1);

        cur_req = "R7";
        wr(4, 32'h3333_3333);
        wander(80, 0, 1);

        cur_req = "R8";
        wr(4, 32'h3210_3210);
        wander(120, 0, 1);

        cur_req = "R9";
        wr(4, 32'hFB73_C6E5);
        wander(60, 0, 1);
        wr(4, 32'h3333_3333);
        check("R9", "pend after mode write", pend_o, 0);

        cur_req = "R10";
        wander(200, 1, 1);
        wr(4, 32'h2121_3131);
        wander(200, 1, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule